// File: doc/BRIEF.md
# Two-Threshold Slope ADC Sequencer

This block controls an external integrating converter. The converter has a reset switch across its integrating capacitor, a charge switch that feeds the input current, and two comparators set at a middle and an upper threshold. In idle the block holds the capacitor shorted. A start request opens the reset switch and closes the charge switch. The integrator then ramps upward, and each comparator output falls as the ramp passes its threshold.

A free-running timer is sampled when the middle comparator falls and again when the upper comparator falls. The block reports the difference of the two samples, taken modulo the timer width. Because both samples lie on the same ramp, the residual capacitor voltage and any constant output offset cancel out. After a result, or after a timeout when the ramp never arrives, the block shorts the capacitor for a discharge period and then a settling period. It then returns to idle or, in continuous mode, starts the next ramp. Converting the interval to a voltage is left to the consumer of the result.

Top module: `slope_adc_seq`

## Requirements
- R1: While reset is held and after it is released, the reset switch control is 1, the charge switch control is 0, valid and timeout are 0, and the interval output is 0.
- R2: In idle, start_i sampled high at a clock edge makes the reset switch 0 and the charge switch 1 from that edge on.
- R3: If the middle comparator falls before edge a and the upper comparator later falls before edge a+N, then valid_o is 1 for exactly one cycle, 3 cycles after the upper fall is sampled, and interval_o equals N at that cycle.
- R4: A falling edge on the upper comparator that arrives before the middle crossing has been captured is ignored. Valid stays 0 and the result is measured to the next upper fall.
- R5: The interval is the capture difference modulo 2^TMR_W. A ramp across which the timer wraps still reports the true cycle count.
- R6: If no result is reached within TIMEOUT_CYC charge cycles, the charge switch stays 1 for exactly TIMEOUT_CYC cycles. timeout_o then pulses for one cycle as the reset switch turns on, valid stays 0 and interval_o keeps its previous value.
- R7: After a result or a timeout, the reset switch stays on for DISCH_CYC + SETTLE_CYC cycles before the next charge phase. With cont_i low, the block remains idle until the next start.
- R8: With cont_i high, conversions follow one another without further start requests.
- R9: Comparator edges while idle have no effect on valid, timeout or the interval.
- R10: The reset switch and charge switch controls are never both 1, and valid and timeout are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion from idle |
| cont_i | input | 1 | Repeat conversions back to back |
| cmp_mid_i | input | 1 | Asynchronous middle-threshold comparator, falls when crossed |
| cmp_hi_i | input | 1 | Asynchronous upper-threshold comparator, falls when crossed |
| rst_sw_o | output | 1 | Capacitor reset switch control |
| chg_sw_o | output | 1 | Charge switch control |
| interval_o | output | TMR_W | Measured interval in clock cycles |
| valid_o | output | 1 | One-cycle strobe for a new interval |
| timeout_o | output | 1 | One-cycle strobe for an aborted charge phase |

## Verification
Each comparator edge passes through two synchroniser flops and an edge register before it reaches the capture logic. The switch controls therefore change one edge after start is sampled, while valid and the interval appear on the third edge after an upper fall is driven. The bench drives inputs on falling clock edges and samples on falling clock edges. It counts those edges from each stimulus, so it checks valid exactly at the third one and confirms that valid is low on the two before and the one after. The timeout and discharge windows are checked by counting the falling edges during which each switch control holds its level.

// File: rtl/slope_pkg.sv
package slope_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_DISCH  = 2'd2,
    ST_SETTLE = 2'd3
  } slope_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/slope_cmp_sync.sv
module slope_cmp_sync #(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] cmp_i,
  output logic [LANES-1:0] fall_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic s1_q, s2_q, s3_q;
    // idle comparators sit high, so reset to 1 to avoid a false edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= cmp_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign fall_o[g] = s3_q & ~s2_q;
  end
endmodule

// File: rtl/slope_timer.sv
module slope_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TMR_W-1:0] tmr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_o <= '0;
    else         tmr_o <= tmr_o + 1'b1;
  end
endmodule

// File: rtl/slope_seq_fsm.sv
module slope_seq_fsm
  import slope_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int TIMEOUT_CYC = 60000,
  parameter int DISCH_CYC   = 64,
  parameter int SETTLE_CYC  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             fall_mid_i,
  input  logic             fall_hi_i,
  input  logic [TMR_W-1:0] tmr_i,
  output logic             rst_sw_o,
  output logic             chg_sw_o,
  output logic [TMR_W-1:0] interval_o,
  output logic             valid_o,
  output logic             timeout_o
);
  localparam int MAXC  = max3(TIMEOUT_CYC, DISCH_CYC, SETTLE_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] DIS_LAST = CNT_W'(DISCH_CYC - 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);

  slope_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             got_mid_q;
  logic [TMR_W-1:0] t2_q;
  logic             done_hi;

  // upper edge counts only once the middle crossing is held
  assign done_hi = got_mid_q & fall_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      got_mid_q  <= 1'b0;
      t2_q       <= '0;
      interval_o <= '0;
      valid_o    <= 1'b0;
      timeout_o  <= 1'b0;
      rst_sw_o   <= 1'b1;
      chg_sw_o   <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_CHARGE;
            cnt_q     <= '0;
            got_mid_q <= 1'b0;
            rst_sw_o  <= 1'b0;
            chg_sw_o  <= 1'b1;
          end
        end
        ST_CHARGE: begin
          cnt_q <= cnt_q + 1'b1;
          if (!got_mid_q && fall_mid_i) begin
            t2_q      <= tmr_i;
            got_mid_q <= 1'b1;
          end
          if (done_hi) begin
            interval_o <= tmr_i - t2_q;  // modulo 2^TMR_W
            valid_o    <= 1'b1;
            state_q    <= ST_DISCH;
            cnt_q      <= '0;
            rst_sw_o   <= 1'b1;
            chg_sw_o   <= 1'b0;
          end else if (cnt_q == TO_LAST) begin
            timeout_o <= 1'b1;
            state_q   <= ST_DISCH;
            cnt_q     <= '0;
            rst_sw_o  <= 1'b1;
            chg_sw_o  <= 1'b0;
          end
        end
        ST_DISCH: begin
          if (cnt_q == DIS_LAST) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cnt_q == SET_LAST) begin
            cnt_q     <= '0;
            got_mid_q <= 1'b0;
            if (cont_i) begin
              state_q  <= ST_CHARGE;
              rst_sw_o <= 1'b0;
              chg_sw_o <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slope_adc_seq.sv
module slope_adc_seq #(
  parameter int TMR_W       = 16,
  parameter int TIMEOUT_CYC = 60000,
  parameter int DISCH_CYC   = 64,
  parameter int SETTLE_CYC  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             cmp_mid_i,
  input  logic             cmp_hi_i,
  output logic             rst_sw_o,
  output logic             chg_sw_o,
  output logic [TMR_W-1:0] interval_o,
  output logic             valid_o,
  output logic             timeout_o
);
  localparam int N_CMP = 2;

  logic [N_CMP-1:0] fall;
  logic [TMR_W-1:0] tmr;

  slope_cmp_sync #(.LANES(N_CMP)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_i  ({cmp_hi_i, cmp_mid_i}),
    .fall_o (fall)
  );

  slope_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tmr_o  (tmr)
  );

  slope_seq_fsm #(
    .TMR_W       (TMR_W),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .DISCH_CYC   (DISCH_CYC),
    .SETTLE_CYC  (SETTLE_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cont_i     (cont_i),
    .fall_mid_i (fall[0]),
    .fall_hi_i  (fall[1]),
    .tmr_i      (tmr),
    .rst_sw_o   (rst_sw_o),
    .chg_sw_o   (chg_sw_o),
    .interval_o (interval_o),
    .valid_o    (valid_o),
    .timeout_o  (timeout_o)
  );
endmodule

// File: rtl/slope_adc_seq_chk.sv
module slope_adc_seq_chk #(
  parameter int TMR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             rst_sw_o,
  input logic             chg_sw_o,
  input logic [TMR_W-1:0] interval_o,
  input logic             valid_o,
  input logic             timeout_o
);
  a_r10_sw_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_sw_o && chg_sw_o));
  a_r10_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && timeout_o));
  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r3_valid_ends_charge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rst_sw_o && !chg_sw_o && $past(chg_sw_o)));
  a_r6_timeout_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  a_r6_timeout_ends_charge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (rst_sw_o && $past(chg_sw_o)));
  a_r6_interval_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(interval_o));
  a_r2_charge_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_sw_o) |-> ($past(start_i) || $past(rst_sw_o)));
endmodule

bind slope_adc_seq slope_adc_seq_chk #(.TMR_W(TMR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .rst_sw_o   (rst_sw_o),
  .chg_sw_o   (chg_sw_o),
  .interval_o (interval_o),
  .valid_o    (valid_o),
  .timeout_o  (timeout_o)
);

// File: tb/slope_adc_seq_test.sv
module slope_adc_seq_test;
  localparam int TMR_W   = 10;
  localparam int TO_CYC  = 1500;
  localparam int DIS_CYC = 6;
  localparam int SET_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cont = 1'b0, cmp_mid = 1'b1, cmp_hi = 1'b1;
  logic rst_sw, chg_sw, valid, timeout;
  logic [TMR_W-1:0] interval;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slope_adc_seq #(
    .TMR_W(TMR_W), .TIMEOUT_CYC(TO_CYC), .DISCH_CYC(DIS_CYC), .SETTLE_CYC(SET_CYC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont),
    .cmp_mid_i(cmp_mid), .cmp_hi_i(cmp_hi),
    .rst_sw_o(rst_sw), .chg_sw_o(chg_sw), .interval_o(interval),
    .valid_o(valid), .timeout_o(timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick();
    start = 1'b1;
    nclk(1);
    start = 1'b0;
  endtask

  // drive middle fall, then upper fall n cycles later; check result timing
  task automatic ramp(input int n, input string req);
    int v;
    nclk(3);
    cmp_mid = 1'b0;
    nclk(n);
    cmp_hi = 1'b0;
    v = 0;
    nclk(1); v += valid;
    nclk(1); v += valid;
    chk(v == 0, req, v, 0);
    nclk(1);
    chk(valid == 1'b1, req, valid, 1);
    chk(interval == TMR_W'(n), req, interval, n);
    cmp_mid = 1'b1;
    cmp_hi  = 1'b1;
  endtask

  task automatic t_reset();
    nclk(3);
    chk(rst_sw && !chg_sw && !valid && !timeout && interval == 0, "R1", {rst_sw, chg_sw, valid, timeout}, 4'b1000);
    rst_n = 1'b1;
    nclk(3);
    chk(rst_sw && !chg_sw && !valid && !timeout && interval == 0, "R1", {rst_sw, chg_sw, valid, timeout}, 4'b1000);
  endtask

  task automatic t_single();
    int hold;
    kick();
    chk(!rst_sw && chg_sw, "R2", {rst_sw, chg_sw}, 2'b01);
    ramp(37, "R3");
    nclk(1);
    chk(valid == 1'b0, "R3", valid, 0);
    hold = 0;
    for (int i = 0; i < 40; i++) begin
      nclk(1);
      hold += chg_sw;
    end
    chk(hold == 0 && rst_sw, "R7", hold, 0);
  endtask

  task automatic t_idle_ignore();
    int v;
    v = 0;
    cmp_mid = 1'b0; nclk(5);
    cmp_hi  = 1'b0; nclk(5);
    cmp_mid = 1'b1; cmp_hi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      nclk(1);
      v += valid + timeout;
    end
    chk(v == 0 && interval == TMR_W'(37) && !chg_sw, "R9", v, 0);
  endtask

  task automatic t_early_hi();
    int v;
    kick();
    nclk(3);
    cmp_hi = 1'b0;
    v = 0;
    for (int i = 0; i < 10; i++) begin
      nclk(1);
      v += valid;
    end
    chk(v == 0 && chg_sw, "R4", v, 0);
    cmp_hi = 1'b1;
    nclk(4);
    ramp(21, "R4");
    nclk(DIS_CYC + SET_CYC + 4);
  endtask

  task automatic t_wrap();
    // 1020 cycles spans a wrap of the 10-bit timer
    kick();
    ramp(1020, "R5");
    nclk(DIS_CYC + SET_CYC + 4);
  endtask

  task automatic t_timeout();
    int hi_cnt, v;
    kick();
    hi_cnt = 0;
    v = 0;
    while (chg_sw && hi_cnt < TO_CYC + 10) begin
      hi_cnt++;
      v += valid;
      nclk(1);
    end
    chk(hi_cnt == TO_CYC, "R6", hi_cnt, TO_CYC);
    chk(timeout == 1'b1 && rst_sw, "R6", timeout, 1);
    chk(v == 0 && valid == 1'b0 && interval == TMR_W'(1020), "R6", interval, 1020);
    nclk(1);
    chk(timeout == 1'b0, "R6", timeout, 0);
    nclk(DIS_CYC + SET_CYC + 4);
  endtask

  task automatic t_cont();
    int gap;
    cont = 1'b1;
    kick();
    ramp(12, "R8");
    gap = 0;
    while (!chg_sw && gap < 50) begin
      gap++;
      nclk(1);
    end
    chk(gap == DIS_CYC + SET_CYC, "R7", gap, DIS_CYC + SET_CYC);
    ramp(55, "R8");
    cont = 1'b0;
    gap = 0;
    while (!chg_sw && gap < 50) begin
      gap++;
      nclk(1);
    end
    chk(gap == 50, "R8", gap, 50);
  endtask

  initial begin
    t_reset();
    t_single();
    t_idle_ignore();
    t_early_hi();
    t_wrap();
    t_timeout();
    t_cont();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule